// File: doc/BRIEF.md
# Receive Character Buffer with Threshold and Idle Timeout Interrupts

This block sits between a serial deserializer and a processor read port. Each received character arrives as an 8-bit data byte plus a 3-bit error tag. Up to 16 of these are kept in arrival order. The processor pulls them out one at a time. The stored count is compared with a selectable threshold to raise a data-available interrupt. A second interrupt flags a partial block that has sat untouched for several character times, so that trailing bytes below the threshold are not stranded.

Both data sides use valid/ready. On the write side, `in_ready` tells the deserializer whether a character can be taken. A deserializer cannot stall, though, so a character offered while `in_ready` is low is not held. It is thrown away and raises a sticky overrun flag. On the read side, `out_valid` is high while anything is stored, and a character leaves on every cycle where `out_valid` and `out_ready` are both high.

Control and status are plain signals: enable, clear, threshold select, interrupt enable, a one-cycle character-time tick from the baud logic, and a status-read strobe that releases the overrun flag.

Top module: `rxbuf_to`

## Requirements
- R1: At most 16 characters are stored. `in_ready` is low when 16 are stored, and `level` never exceeds 16.
- R2: Characters leave in arrival order with their error tags. `out_valid` equals (level != 0), and a pop happens on a cycle with `out_valid` and `out_ready` both high.
- R3: `trig_sel` selects the threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. `irq_data` is high exactly when `irq_en` is high and level is at or above the threshold.
- R4: When `en` is high and a character is offered while `in_ready` is low, the character is discarded, the stored contents are unchanged, and `overrun` goes high on the next cycle.
- R5: `overrun` stays high until a cycle with `stat_rd` high. If an overrun and `stat_rd` occur in the same cycle, the flag ends that cycle set.
- R6: With `irq_en` high and at least one character stored, `irq_timeout` rises on the cycle after the 4th `char_tick` that has arrived since the last accepted push or pop.
- R7: An accepted push or a pop restarts the idle count, and `irq_timeout` is low on the following cycle.
- R8: A `clr` pulse empties the buffer on the next cycle. It wins over a push or pop in the same cycle and leaves `overrun` untouched.
- R9: While `en` is low the buffer is held empty, `in_ready` is low, and offered characters are dropped without setting `overrun`. Raising `en` therefore starts from an empty buffer.
- R10: With `irq_en` low, `irq_data` and `irq_timeout` are both low.
- R11: After reset the level is 0, `out_valid`, both interrupts and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Buffer enable; while low the buffer is held empty |
| clr | input | 1 | One-cycle pulse that empties the buffer |
| trig_sel | input | 2 | Threshold select code |
| irq_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One-cycle pulse per character time |
| stat_rd | input | 1 | Status read strobe; clears overrun |
| in_valid | input | 1 | Deserializer offers a character |
| in_ready | output | 1 | Space available |
| in_data | input | 8 | Received byte |
| in_err | input | 3 | Error tag for the byte |
| out_valid | output | 1 | At least one character stored |
| out_ready | input | 1 | Processor read strobe |
| out_data | output | 8 | Oldest byte |
| out_err | output | 3 | Error tag of the oldest byte |
| level | output | 5 | Number of characters stored |
| irq_data | output | 1 | Threshold reached interrupt |
| irq_timeout | output | 1 | Idle partial-block interrupt |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach from the ports is the exact idle boundary. The timeout must stay low after three character ticks and rise only after the fourth, and it must drop again the moment a pop or push arrives. The stimulus sets the highest threshold so that a few stored bytes never trigger the data interrupt. It then issues single ticks one at a time and checks the flag after each one, and finally restarts the count with a pop and with a push. Overrun on a full buffer is reached by filling all 16 entries and offering extra bytes. This includes one offer in the same cycle as a status read, which checks that setting the flag wins over clearing it.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  // threshold encoding: 00->1, 01->4, 10->8, 11->14
  function automatic int unsigned trig_count(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_count = 1;
      2'b01:   trig_count = 4;
      2'b10:   trig_count = 8;
      default: trig_count = 14;
    endcase
  endfunction
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R8
endmodule

// File: rtl/rxbuf_timer.sv
module rxbuf_timer #(
  parameter int TO_CHARS = 4,
  localparam int TW      = $clog2(TO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic holding,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      cnt <= '0;
    else if (restart || !holding)                    cnt <= '0;
    else if (tick && cnt != TW'(TO_CHARS))           cnt <= cnt + TW'(1);
  end

  assign expired = holding && (cnt == TW'(TO_CHARS));

  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired); // R7
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          to_hit,
  input  logic          ovr_set,
  input  logic          stat_rd,
  output logic          irq_data,
  output logic          irq_timeout,
  output logic          overrun
);
  logic [CW-1:0] thresh;

  assign thresh      = CW'(trig_count(trig_sel));
  assign irq_data    = irq_en && (count >= thresh);
  assign irq_timeout = irq_en && to_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (ovr_set) overrun <= 1'b1;
    else if (stat_rd) overrun <= 1'b0;
  end

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !stat_rd |=> overrun); // R5
endmodule

// File: rtl/rxbuf_to.sv
module rxbuf_to
  import rxbuf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int EW      = DATA_W + ERR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [1:0]        trig_sel,
  input  logic              irq_en,
  input  logic              char_tick,
  input  logic              stat_rd,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ERR_W-1:0]  in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ERR_W-1:0]  out_err,
  output logic [CW-1:0]     level,
  output logic              irq_data,
  output logic              irq_timeout,
  output logic              overrun
);
  rx_char_t      wchar, rchar;
  logic [EW-1:0] rbits;
  logic          full, push, pop, flush, ovr_set, to_hit;

  assign full      = (level == CW'(DEPTH));
  assign in_ready  = en && !full;
  assign out_valid = (level != '0);
  assign flush     = clr || !en;
  assign push      = en && !clr && in_valid && !full;
  assign pop       = en && !clr && out_ready && out_valid;
  assign ovr_set   = en && in_valid && full;

  assign wchar = '{err: in_err, data: in_data};
  assign rchar = rx_char_t'(rbits);
  assign out_data = rchar.data;
  assign out_err  = rchar.err;

  rxbuf_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(wchar), .rdata(rbits), .count(level)
  );

  rxbuf_timer #(.TO_CHARS(TO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(push || pop || flush),
    .holding(level != '0), .tick(char_tick), .expired(to_hit)
  );

  rxbuf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .count(level), .trig_sel(trig_sel),
    .irq_en(irq_en), .to_hit(to_hit), .ovr_set(ovr_set), .stat_rd(stat_rd),
    .irq_data(irq_data), .irq_timeout(irq_timeout), .overrun(overrun)
  );

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en && in_valid && !in_ready |=> overrun); // R4
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    en && in_valid && !in_ready && !clr && !out_ready |=> $stable(level)); // R4
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_data |-> out_valid); // R3
  AST_DIS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> level == '0 && !in_ready); // R9
endmodule

// File: tb/tb_rxbuf_to.sv
module tb_rxbuf_to;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 1'b1, clr = 1'b0, irq_en = 1'b1, char_tick = 1'b0, stat_rd = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] in_err = '0;
  logic       in_ready, out_valid, irq_data, irq_timeout, overrun;
  logic [7:0] out_data;
  logic [2:0] out_err;
  logic [4:0] level;

  int checks = 0, failures = 0;
  logic [10:0] sb[$];
  bit en_model = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_to dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares every popped character against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && out_ready && out_valid) begin
      if (sb.size() == 0) check(0, "R2 pop of empty model", 1, 0);
      else begin
        logic [10:0] e;
        e = sb.pop_front();
        check({out_err, out_data} == e, "R2 order/data", {out_err, out_data}, e);
      end
    end
  end

  task automatic push_byte(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_err = e;
    if (en_model && sb.size() < 16) sb.push_back({e, d});
    @(negedge clk);
    in_valid = 1'b0;
    #2;
  endtask

  task automatic pop_one();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    #2;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1'b1;
    @(negedge clk); char_tick = 1'b0;
    #2;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    sb.delete();
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int trig_tab[4];
    trig_tab = '{1, 4, 8, 14};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11 reset state
    check(level == 0 && !out_valid, "R11 level", level, 0);
    check(!irq_data && !irq_timeout && !overrun, "R11 flags",
          {irq_data, irq_timeout, overrun}, 0);
    check(in_ready, "R1 ready when empty", in_ready, 1);

    // R2 ordering with error tags
    push_byte(8'hA5, 3'b001);
    push_byte(8'h3C, 3'b100);
    push_byte(8'h00, 3'b010);
    check(level == 3 && out_valid, "R2 level after 3 pushes", level, 3);
    repeat (3) pop_one();
    check(level == 0 && !out_valid, "R2 drained", level, 0);

    // R3 thresholds for every code
    for (int s = 0; s < 4; s++) begin
      do_clear();
      trig_sel = 2'(s);
      for (int n = 1; n <= trig_tab[s]; n++) begin
        if (n == trig_tab[s])
          check(!irq_data, "R3 below threshold", irq_data, 0);
        push_byte(8'(16 * s + n), 3'b000);
      end
      check(irq_data, "R3 at threshold", irq_data, 1);
    end

    // R10 interrupt mask
    irq_en = 1'b0; #1;
    check(!irq_data, "R10 irq_data masked", irq_data, 0);
    irq_en = 1'b1;

    // R1/R4/R5 fill and overrun
    do_clear();
    trig_sel = 2'b11;
    for (int i = 0; i < 16; i++) push_byte(8'(8'h40 + i), 3'(i));
    check(level == 16 && !in_ready, "R1 full", level, 16);
    check(!overrun, "R4 no overrun before extra", overrun, 0);
    push_byte(8'hEE, 3'b111);
    check(overrun, "R4 overrun set", overrun, 1);
    check(level == 16, "R4 level unchanged", level, 16);
    @(negedge clk); stat_rd = 1'b1; in_valid = 1'b1; in_data = 8'hDD;
    @(negedge clk); stat_rd = 1'b0; in_valid = 1'b0; #2;
    check(overrun, "R5 set wins over status read", overrun, 1);
    repeat (3) @(negedge clk);
    #2;
    check(overrun, "R5 sticky", overrun, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; #2;
    check(!overrun, "R5 cleared by status read", overrun, 0);
    for (int i = 0; i < 16; i++) pop_one();
    check(level == 0 && sb.size() == 0, "R4 rejected bytes absent", level, 0);

    // R6/R7 idle timeout
    push_byte(8'h11, 3'b000);
    push_byte(8'h22, 3'b000);
    for (int t = 1; t <= 3; t++) begin
      tick();
      check(!irq_timeout, "R6 early", irq_timeout, 0);
    end
    tick();
    check(irq_timeout, "R6 after 4 ticks", irq_timeout, 1);
    check(!irq_data, "R3 below 14", irq_data, 0);
    irq_en = 1'b0; #1;
    check(!irq_timeout, "R10 timeout masked", irq_timeout, 0);
    irq_en = 1'b1; #1;
    pop_one();
    check(!irq_timeout, "R7 cleared by pop", irq_timeout, 0);
    repeat (4) tick();
    check(irq_timeout, "R6 re-armed", irq_timeout, 1);
    push_byte(8'h33, 3'b000);
    check(!irq_timeout, "R7 cleared by push", irq_timeout, 0);

    // R8 clear wins over push, leaves overrun alone
    @(negedge clk); clr = 1'b1; in_valid = 1'b1; in_data = 8'h77;
    @(negedge clk); clr = 1'b0; in_valid = 1'b0; #2;
    sb.delete();
    check(level == 0, "R8 cleared with push", level, 0);
    check(!irq_timeout, "R8 no timeout when empty", irq_timeout, 0);

    // R9 disabled
    @(negedge clk); en = 1'b0; en_model = 1'b0;
    #2;
    check(!in_ready, "R9 not ready", in_ready, 0);
    push_byte(8'h99, 3'b000);
    check(level == 0 && !overrun, "R9 dropped silently", level, 0);
    @(negedge clk); en = 1'b1; en_model = 1'b1;
    #2;
    check(level == 0 && in_ready, "R9 re-enabled empty", level, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule